// File: doc/BRIEF.md
# CRC-16 Frame Encoder

This block turns one data word into one transmit frame in a single clock cycle. The data word is 8 or 16 bits wide, chosen at build time. The frame holds a 16-bit check field in its upper bits and the unchanged data word in its lower bits. The check field is the remainder of a modulo-2 polynomial division of the data by a fixed 16-bit generator.

The division is written out as a chain of one-bit division steps. The chain settles within one cycle, and its result is captured in a frame register. An upstream producer presents a word together with a one-cycle strobe. The frame appears on the output one cycle later with its own strobe. The frame register holds its last value until the next strobe arrives.

Top module: `crc16_frame_enc`

## Requirements
- R1: The generator is x^16 + x^12 + x^5 + 1. Its taps are written as the 16-bit constant 0x1021, with bit positions 12, 5 and 0 set. The check field is 16 bits wide.
- R2: The remainder starts from all zeros for every word, so an all-zero data word gives an all-zero check field. No remainder state carries over from one word to the next.
- R3: Data bit 0 enters the division first and bit DATA_W-1 enters last. At each step the feedback bit is the data bit XOR remainder bit 15. The remainder shifts left by one, and when the feedback bit is 1 it is then XORed with 0x1021.
- R4: out_frame is DATA_W+16 bits wide. Bits [DATA_W+15:DATA_W] carry the check field, and bits [DATA_W-1:0] carry the data word unchanged. This gives 32 bits for 16-bit data and 24 bits for 8-bit data.
- R5: out_valid is high in exactly the cycle after a cycle in which in_valid was high, and low in every other cycle.
- R6: out_frame loads only on a cycle with in_valid high. While in_valid is low, out_frame keeps its previous value, whatever in_data does.
- R7: A synchronous active-high reset clears out_frame to zero and out_valid to 0. Reset takes priority over a strobe in the same cycle.
- R8: Strobes on consecutive cycles each produce their own frame, one per cycle, in order, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data word strobe |
| in_data | input | DATA_W | Data word to encode |
| out_valid | output | 1 | Frame strobe, one cycle after in_valid |
| out_frame | output | DATA_W+16 | Registered frame: check field above data |

## Verification
The hardest behaviour to confirm from the ports is the bit order of the division. A wrong order would still give zero for zero data and could look plausible for all-ones data. The stimulus therefore sends every one-hot data word in turn. Each one-hot word isolates one stage of the unrolled chain, so a swapped or misrouted stage gives a check field that differs from the serial reference. Back-to-back strobes, and a reset that lands on the same edge as a strobe, reach the register-update corners that isolated words cannot.

// File: rtl/crc16_enc_pkg.sv
package crc16_enc_pkg;
    localparam int unsigned CRC_W = 16;
    // Generator x^16 + x^12 + x^5 + 1, implicit x^16 term dropped
    localparam logic [CRC_W-1:0] GEN_TAPS = 16'h1021;
    typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc16_enc_step.sv
// One step of the modulo-2 division: absorbs a single data bit.
module crc16_enc_step
    import crc16_enc_pkg::*;
(
    input  crc_t rem_i,
    input  logic bit_i,
    output crc_t rem_o
);
    logic fb;

    always_comb begin
        fb    = bit_i ^ rem_i[CRC_W-1];
        rem_o = {rem_i[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & GEN_TAPS);
    end
endmodule

// File: rtl/crc16_enc_unroll.sv
// Unrolled chain of DATA_W division steps, bit 0 absorbed first (R3).
module crc16_enc_unroll
    import crc16_enc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    output crc_t              check_o
);
    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_stage
            crc_t rem_in;
            crc_t rem_out;
            if (i == 0) begin : g_first
                assign rem_in = '0;   // remainder starts from zero (R2)
            end else begin : g_next
                assign rem_in = g_stage[i-1].rem_out;
            end
            crc16_enc_step u_step (
                .rem_i (rem_in),
                .bit_i (data_i[i]),
                .rem_o (rem_out)
            );
        end
    endgenerate

    assign check_o = g_stage[DATA_W-1].rem_out;
endmodule

// File: rtl/crc16_frame_enc.sv
module crc16_frame_enc
    import crc16_enc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    out_valid,
    output logic [DATA_W+CRC_W-1:0] out_frame
);
    localparam int unsigned FRAME_W = DATA_W + CRC_W;

    typedef struct packed {
        logic               vld;
        logic [FRAME_W-1:0] frame;
    } state_t;

    state_t state_d, state_q;
    crc_t   check_w;

    crc16_enc_unroll #(.DATA_W(DATA_W)) u_unroll (
        .data_i  (in_data),
        .check_o (check_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.frame = {check_w, in_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_frame = state_q.frame;

    // R5: a strobe yields a frame strobe on the next cycle
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R5: no strobe, no frame strobe
    assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R6: frame holds when no strobe
    assert_frame_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_frame));
    // R4: data field carries the strobed word unchanged
    assert_data_field_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_frame[DATA_W-1:0] == $past(in_data)));
    // R2: zero word gives zero check field
    assert_zero_check_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == '0) |=> (out_frame[FRAME_W-1:DATA_W] == '0));
    // R7: reset clears the output register
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_frame == '0));
endmodule

// File: tb/crc16_frame_enc_tb_top.sv
`timescale 1ns/100ps
module crc16_frame_enc_tb_top;
    localparam int DW = 16;
    localparam int FW = DW + 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [FW-1:0] out_frame;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    crc16_frame_enc #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_frame (out_frame)
    );

    // Serial reference from R1/R3: bit 0 first, shift left, taps 0x1021
    function automatic logic [15:0] ref_crc(logic [DW-1:0] d);
        logic [15:0] r = '0;
        for (int i = 0; i < DW; i++) begin
            logic top;
            top = r[15];
            r = {r[14:0], 1'b0};
            if (top != d[i]) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Strobe one word, then check the frame at the next negedge
    task automatic send_and_check(string tag, logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R5 valid"}, 64'(out_valid), 64'd1);
        check({tag, " R4 frame"}, 64'(out_frame), 64'({ref_crc(d), d}));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 reset valid", 64'(out_valid), 64'd0);
        check("R7 reset frame", 64'(out_frame), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_zero_ones();
        send_and_check("R2 zero word", '0);
        send_and_check("R1 all ones", '1);
        @(negedge clk);
        check("R5 valid low after", 64'(out_valid), 64'd0);
    endtask

    task automatic t_one_hot();
        for (int b = 0; b < DW; b++) begin
            send_and_check("R3 one-hot", DW'(1) << b);
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            send_and_check("R1 random", DW'($urandom));
        end
    endtask

    task automatic t_back_to_back();
        logic [DW-1:0] w [3];
        for (int k = 0; k < 3; k++) w[k] = DW'($urandom);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w[0];
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            in_data = w[k];
            check("R8 b2b valid", 64'(out_valid), 64'd1);
            check("R8 b2b frame", 64'(out_frame), 64'({ref_crc(w[k-1]), w[k-1]}));
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 b2b last", 64'(out_frame), 64'({ref_crc(w[2]), w[2]}));
    endtask

    task automatic t_hold();
        logic [DW-1:0] d = 16'hA5C3;
        send_and_check("R6 load", d);
        for (int k = 0; k < 3; k++) begin
            in_data = DW'($urandom);
            @(negedge clk);
            check("R6 hold frame", 64'(out_frame), 64'({ref_crc(d), d}));
            check("R5 hold valid", 64'(out_valid), 64'd0);
        end
    endtask

    task automatic t_reset_priority();
        send_and_check("R7 pre", 16'h1234);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_data  = 16'hFFFF;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R7 prio valid", 64'(out_valid), 64'd0);
        check("R7 prio frame", 64'(out_frame), 64'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_zero_ones();
        t_one_hot();
        t_random();
        t_back_to_back();
        t_hold();
        t_reset_priority();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule